// File: doc/BRIEF.md
# Primary Clock Loss Monitor with Backup Select

This block decides whether a primary clock is still running. It uses a second, always-present reference clock as its time base. Each rising edge of the primary clock flips a single bit in the primary domain. That bit crosses into the reference domain through a synchronizer, and a change detector turns each observed flip into an activity event. A counter in the reference domain measures how many reference cycles have passed since the last event. When that count reaches the timeout chosen by a select pin, a loss flag is raised.

The loss flag drives a select output for a downstream clock multiplexer, which moves to the backup clock while the primary is quiet. Failover and recovery are deliberately asymmetric. Declaring a loss takes a full timeout of 3 or 48 reference periods. Returning to the primary happens on the first activity event, with no hold-off and no hysteresis count. Only the primary clock is watched. The reference clock is assumed to be present whenever the block is in use.

Top module: `clkmon_failover`

## Requirements
- R1: While `rst_n` is low, `lost_o` is 0 and `mux_sel_o` is 0 (primary selected), whatever the state was before reset.
- R2: After `rst_n` rises with the primary clock idle, `lost_o` goes high on exactly the N-th rising edge of `clk_ref`, where N is 48 with `long_sel`=1 and 3 with `long_sel`=0.
- R3: With `long_sel`=0, `lost_o` is high from the 6th reference rising edge after the last primary rising edge onward. It is low at the 3rd and 4th edges. This is a 3-period timeout plus 3 edges of synchronizer and detector latency.
- R4: With `long_sel`=1, `lost_o` is high from the 51st reference rising edge after the last primary rising edge onward. It is low from the 3rd through the 49th edge.
- R5: A single primary rising edge clears a raised `lost_o` by the 3rd reference rising edge after it, with no recovery timeout. `lost_o` is still high after the 2nd edge.
- R6: `mux_sel_o` equals `lost_o` at all times: 1 selects the backup clock and 0 selects the primary clock.
- R7: If `long_sel` falls from 1 to 0 while the quiet time already counted is 3 or more, `lost_o` rises on the next reference rising edge.
- R8: Once raised, `lost_o` is cleared only by primary activity. Moving `long_sel` from 0 to 1 does not lower it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri | input | 1 | Primary clock being monitored |
| clk_ref | input | 1 | Reference/backup clock, time base of the timeout |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| long_sel | input | 1 | Timeout select: 1 = 48 reference periods, 0 = 3 |
| lost_o | output | 1 | Primary clock declared lost |
| mux_sel_o | output | 1 | Clock mux select, 1 = backup |

## Verification
A stuck or mis-cleared quiet counter shows up at `lost_o` as a loss edge on the wrong reference cycle. The bench counts reference edges from the last primary edge, so an early or late rise is seen within one reference period. A lost activity event, for example from a broken synchronizer stage or a missing change detector, leaves `lost_o` high after the primary has resumed, and this is visible three reference edges after any primary edge. A wrong select polarity or a non-sticky flag is seen on `mux_sel_o` or `lost_o` at the very next sample.

// File: rtl/clkmon_pkg.sv
`timescale 1ns/1ps
package clkmon_pkg;

   // Meaning of a high level on the mux select output
   typedef enum logic {
      SEL_HIGH_IS_PRIMARY = 1'b0,
      SEL_HIGH_IS_BACKUP  = 1'b1
   } sel_pol_e;

   // Timeout in reference periods for a given select level
   function automatic int ticks_for(logic long_mode, int short_t, int long_t);
      return long_mode ? long_t : short_t;
   endfunction

endpackage

// File: rtl/clkmon_toggle.sv
`timescale 1ns/1ps
// Primary-domain activity marker: flips on every primary rising edge.
module clkmon_toggle (
   input  logic clk_pri,
   input  logic rst_n,
   output logic tog_o
);
   logic tog_q;

   always_ff @(posedge clk_pri or negedge rst_n) begin
      if (!rst_n) tog_q <= 1'b0;
      else        tog_q <= ~tog_q;
   end

   assign tog_o = tog_q;
endmodule

// File: rtl/clkmon_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer into the reference domain.
module clkmon_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] stg_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= 1'b0;
            else        stg_q[i] <= (i == 0) ? d_i : stg_q[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clkmon_activity.sv
`timescale 1ns/1ps
// Change detector: one-cycle event whenever the synchronized marker flips.
module clkmon_activity (
   input  logic clk,
   input  logic rst_n,
   input  logic mark_i,
   output logic act_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= mark_i;
   end

   assign act_o = mark_i ^ prev_q;
endmodule

// File: rtl/clkmon_timer.sv
`timescale 1ns/1ps
// Quiet-time counter and sticky loss flag in the reference domain.
module clkmon_timer
   import clkmon_pkg::*;
#(
   parameter int SHORT_TICKS = 3,
   parameter int LONG_TICKS  = 48,
   localparam int CW = $clog2(LONG_TICKS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          long_sel,
   input  logic          act_i,
   output logic [CW-1:0] cnt_o,
   output logic          lost_o
);
   localparam logic [CW-1:0] CNT_TOP = CW'(LONG_TICKS);

   logic [CW-1:0] cnt_q;
   logic          lost_q;
   logic [CW:0]   cnt_inc;
   logic [CW:0]   limit;
   logic          reach;

   always_comb begin
      cnt_inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
      limit   = (CW+1)'(ticks_for(long_sel, SHORT_TICKS, LONG_TICKS));
      reach   = (cnt_inc >= limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         lost_q <= 1'b0;
      end else if (act_i) begin
         cnt_q  <= '0;      // any activity restarts the quiet count (R5)
         lost_q <= 1'b0;
      end else begin
         if (cnt_q != CNT_TOP) cnt_q <= cnt_inc[CW-1:0];
         if (reach) lost_q <= 1'b1;   // sticky until activity (R8)
      end
   end

   assign cnt_o  = cnt_q;
   assign lost_o = lost_q;
endmodule

// File: rtl/clkmon_failover.sv
`timescale 1ns/1ps
module clkmon_failover
   import clkmon_pkg::*;
#(
   parameter int       SHORT_TICKS = 3,
   parameter int       LONG_TICKS  = 48,
   parameter int       SYNC_STAGES = 2,
   parameter sel_pol_e SEL_POL     = SEL_HIGH_IS_BACKUP
) (
   input  logic clk_pri,
   input  logic clk_ref,
   input  logic rst_n,
   input  logic long_sel,
   output logic lost_o,
   output logic mux_sel_o
);
   localparam int CW = $clog2(LONG_TICKS + 1);

   generate
      if (SHORT_TICKS < 1 || LONG_TICKS <= SHORT_TICKS) begin : g_bad_ticks
         $error("clkmon_failover: need 1 <= SHORT_TICKS < LONG_TICKS");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("clkmon_failover: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic          tog_w;
   logic          mark_w;
   logic          act_w;
   logic [CW-1:0] cnt_w;
   logic          lost_w;

   clkmon_toggle u_toggle (
      .clk_pri (clk_pri),
      .rst_n   (rst_n),
      .tog_o   (tog_w)
   );

   clkmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_ref),
      .rst_n (rst_n),
      .d_i   (tog_w),
      .q_o   (mark_w)
   );

   clkmon_activity u_activity (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .mark_i (mark_w),
      .act_o  (act_w)
   );

   clkmon_timer #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_timer (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .long_sel (long_sel),
      .act_i    (act_w),
      .cnt_o    (cnt_w),
      .lost_o   (lost_w)
   );

   assign lost_o = lost_w;

   generate
      if (SEL_POL == SEL_HIGH_IS_BACKUP) begin : g_sel_backup
         assign mux_sel_o = lost_w;
      end else begin : g_sel_primary
         assign mux_sel_o = ~lost_w;
      end
   endgenerate
endmodule

// File: rtl/clkmon_failover_chk.sv
`timescale 1ns/1ps
module clkmon_failover_chk #(
   parameter int SHORT_TICKS = 3,
   parameter int LONG_TICKS  = 48,
   localparam int CW = $clog2(LONG_TICKS + 1)
) (
   input logic          clk_ref,
   input logic          rst_n,
   input logic          long_sel,
   input logic          act,
   input logic [CW-1:0] cnt,
   input logic          lost
);
   // Independent count of reference cycles without an activity event
   logic [CW:0] quiet_q;
   int          thr;
   int          quiet_next;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)                          quiet_q <= '0;
      else if (act)                        quiet_q <= '0;
      else if (int'(quiet_q) < LONG_TICKS) quiet_q <= quiet_q + 1'b1;
   end

   always_comb begin
      thr        = long_sel ? LONG_TICKS : SHORT_TICKS;
      quiet_next = int'(quiet_q) + 1;
   end

   AST_CLEAR_ON_ACTIVITY: assert property (@(posedge clk_ref) disable iff (!rst_n)
      act |=> !lost); // R5

   AST_LOSS_STICKY: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (lost && !act) |=> lost); // R8

   AST_LOSS_AT_TIMEOUT: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!act && quiet_next >= thr) |=> lost); // R3

   AST_NO_EARLY_LOSS: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!lost && !act && quiet_next < thr) |=> !lost); // R2

   AST_COUNT_BOUNDED: assert property (@(posedge clk_ref) disable iff (!rst_n)
      int'(cnt) <= LONG_TICKS); // R4
endmodule

bind clkmon_failover clkmon_failover_chk #(
   .SHORT_TICKS (SHORT_TICKS),
   .LONG_TICKS  (LONG_TICKS)
) u_chk (
   .clk_ref  (clk_ref),
   .rst_n    (rst_n),
   .long_sel (long_sel),
   .act      (act_w),
   .cnt      (cnt_w),
   .lost     (lost_w)
);

// File: tb/clkmon_failover_bench.sv
`timescale 1ns/1ps
module clkmon_failover_bench;
   logic clk_pri = 1'b0;
   logic clk_ref = 1'b0;
   logic rst_n   = 1'b0;
   logic long_sel = 1'b1;
   logic lost;
   logic msel;

   int total = 0;
   int bad   = 0;
   bit mon_en = 1'b0;
   bit done   = 1'b0;
   int ref_idx  = 0;
   int last_pri = 0;

   real per_tab [5] = '{11.317, 13.71, 17.093, 23.9, 37.31};

   clkmon_failover u_clkmon_failover (
      .clk_pri   (clk_pri),
      .clk_ref   (clk_ref),
      .rst_n     (rst_n),
      .long_sel  (long_sel),
      .lost_o    (lost),
      .mux_sel_o (msel)
   );

   always #5 clk_ref = ~clk_ref;   // 100 MHz reference

   always @(posedge clk_ref) ref_idx = ref_idx + 1;
   always @(posedge clk_pri) last_pri = ref_idx;

   function automatic int thr_of(logic ls);
      return ls ? 48 : 3;
   endfunction

   // 1 = must be lost, 0 = must be present, 2 = boundary cycle, not checked
   function automatic int exp_lost(int n, int thr);
      if (n >= thr + 3) return 1;
      if (n >= 3 && n <= thr + 1) return 0;
      return 2;
   endfunction

   task automatic chk(string req, logic act_v, logic exp_v);
      total++;
      if (act_v !== exp_v) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act_v, exp_v, $time);
      end
   endtask

   task automatic chk_int(string req, int act_v, int exp_v);
      total++;
      if (act_v != exp_v) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
      end
   endtask

   task automatic pri_run(real per, int edges);
      real h;
      h = per / 2.0;
      repeat (edges) begin
         clk_pri = 1'b1; #(h);
         clk_pri = 1'b0; #(h);
      end
   endtask

   task automatic pri_pulse();
      @(negedge clk_ref);
      #2 clk_pri = 1'b1;
      #2 clk_pri = 1'b0;
   endtask

   task automatic count_to_loss(output int k);
      k = 0;
      for (int i = 1; i <= 100 && k == 0; i++) begin
         @(negedge clk_ref);
         if (lost === 1'b1) k = i;
      end
   endtask

   // Continuous monitor for random phase
   always @(negedge clk_ref) begin
      if (mon_en) begin
         int n, e;
         n = ref_idx - last_pri;
         e = exp_lost(n, thr_of(long_sel));
         if (e != 2) begin
            if (long_sel) chk("R4", lost, e[0]);
            else          chk("R3", lost, e[0]);
         end
         chk("R6", msel, lost);
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int k;
      void'($urandom(32'h5eed));
      // R1: reset state
      repeat (3) @(negedge clk_ref);
      chk("R1", lost, 1'b0);
      chk("R1", msel, 1'b0);

      // R2: long timeout after reset release
      rst_n = 1'b1;
      count_to_loss(k);
      chk_int("R2", k, 48);
      chk("R6", msel, 1'b1);

      // R1: reset clears a raised loss
      rst_n = 1'b0;
      @(negedge clk_ref);
      chk("R1", lost, 1'b0);
      chk("R1", msel, 1'b0);
      long_sel = 1'b0;
      @(negedge clk_ref);
      rst_n = 1'b1;
      count_to_loss(k);
      chk_int("R2", k, 3);

      // R5: single primary edge clears loss, then R3 exact re-loss
      pri_pulse();
      @(negedge clk_ref);
      @(negedge clk_ref);
      chk("R5", lost, 1'b1);
      @(negedge clk_ref);
      chk("R5", lost, 1'b0);
      chk("R6", msel, 1'b0);
      @(negedge clk_ref);
      @(negedge clk_ref);
      chk("R3", lost, 1'b0);
      @(negedge clk_ref);
      chk("R3", lost, 1'b1);

      // R8: widening the timeout does not drop a raised loss
      long_sel = 1'b1;
      repeat (10) @(negedge clk_ref);
      chk("R8", lost, 1'b1);

      // R7: narrowing the timeout past the count raises loss next edge
      pri_pulse();
      repeat (3) @(negedge clk_ref);
      chk("R5", lost, 1'b0);
      repeat (17) @(negedge clk_ref);
      chk("R4", lost, 1'b0);
      long_sel = 1'b0;
      @(negedge clk_ref);
      chk("R7", lost, 1'b1);

      // Random phase: bursts at varied periods, gaps around the timeout
      pri_run(11.317, 3);
      mon_en = 1'b1;
      for (int t = 0; t < 40; t++) begin
         int gap;
         real per;
         pri_run(11.317, 4);
         long_sel = 1'($urandom % 2);
         pri_run(11.317, 4);
         per = per_tab[$urandom % 5];
         pri_run(per, 3 + int'($urandom % 8));
         gap = thr_of(long_sel) + int'($urandom % 10);
         repeat (gap) @(posedge clk_ref);
      end
      mon_en = 1'b0;

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule